// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

The block gives a set of requesters fair, first-come-first-served mutual exclusion over a small number of independent locks. Each lock keeps two counters: a ticket dispenser and a serving counter. When a requester asks for a lock, it receives the current dispenser value as its ticket, and the dispenser advances by one. This read-modify-write happens exactly once per acquire, at the moment the request arrives, whether or not the lock is free at that time. A requester becomes the owner when the serving counter reaches its ticket. A release by the owner advances the serving counter, which passes ownership to the next ticket in line.

Each requester has three signals. The acquire pulse carries a lock index. The release pulse frees the lock it holds. The registered grant output stays high while that requester owns its lock. Every requester also has a one-cycle error output. It flags a release from a requester that does not hold a grant. Such a release changes nothing else. Both counters are just wide enough to count the requesters and wrap around freely. Ownership is decided by equality, so the wrap has no effect on ordering.

Top module: `tkl_unit`

## Requirements
- R1: After reset every grant and every error output is low, and every lock is free.
- R2: A requester in the idle state is one that has no ticket and no grant. When an idle requester pulses acquire for a free lock at rising edge t, its grant is high after edge t+1.
- R3: At most one requester holds the grant of a given lock at any time.
- R4: Requesters that acquire the same lock in different cycles are granted in the order of their acquire cycles.
- R5: Requesters that acquire the same lock in the same cycle are ordered by ascending requester index. Index 0 comes first.
- R6: When the owner pulses release at edge t, its grant is low after edge t. If another requester is waiting, the next ticket's grant is high after edge t+1.
- R7: A release from a requester whose grant is low is ignored. No grant changes, and that requester's error output is high for exactly the one cycle after the edge.
- R8: An acquire from a requester that is already waiting or holding is ignored and takes no ticket. A single release by the owner still frees the lock for later requesters.
- R9: Locks are independent. Owners of different locks may hold grants at the same time. The lock index is bit field i of `acq_lock_i` for requester i, LOCK_W bits wide.
- R10: Both counters wrap modulo 2 to the power of their width. Grant order stays correct over more acquires than the counter range.
- R11: An acquire is a single-cycle pulse taken on arrival. A requester that pulses acquire for a busy lock and then drops the line is still granted in its turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acq_i | input | NUM_REQ | Acquire pulse, one bit per requester |
| acq_lock_i | input | NUM_REQ*LOCK_W | Lock index for each requester's acquire; field i belongs to requester i |
| rel_i | input | NUM_REQ | Release pulse, one bit per requester |
| grant_o | output | NUM_REQ | Registered ownership flag per requester |
| err_o | output | NUM_REQ | One-cycle flag for a release without a grant |

## Verification
An acquire taken at edge t assigns the ticket at that edge. The grant appears after edge t+1 at the earliest. A release at edge t drops the grant after edge t. The successor's grant follows after edge t+1, and an ignored release shows on the error output after edge t. The bench drives inputs on the falling edge and steps a queue-based model at each rising edge using the inputs that edge saw. It compares the grant and error vectors against the model on the following falling edge, and a few phases also compare against literal expected vectors at the same sample points.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } req_state_e;

  // number of set bits of v strictly below position idx
  function automatic int count_below(input logic [31:0] v, input int idx);
    int n;
    n = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < idx && v[k]) n++;
    end
    return n;
  endfunction

  // total number of set bits of v
  function automatic int count_all(input logic [31:0] v);
    return count_below(v, 32);
  endfunction

endpackage

// File: rtl/tkl_slot.sv
module tkl_slot #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] take_cnt_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] next_o,
  output logic [CNT_W-1:0] serving_o
);

  logic [CNT_W-1:0] next_q, serving_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      next_q    <= '0;
      serving_q <= '0;
    end else begin
      next_q <= next_q + take_cnt_i;
      if (advance_i) serving_q <= serving_q + 1'b1;
    end
  end

  assign next_o    = next_q;
  assign serving_o = serving_q;

endmodule

// File: rtl/tkl_client.sv
module tkl_client
  import tkl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int LOCK_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [LOCK_W-1:0] sel_i,
  input  logic [CNT_W-1:0]  ticket_i,
  input  logic [CNT_W-1:0]  serving_i,
  input  logic              rel_i,
  output logic              idle_o,
  output logic              grant_o,
  output logic              err_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic [CNT_W-1:0]  ticket_o
);

  req_state_e        state_q;
  logic [CNT_W-1:0]  ticket_q;
  logic [LOCK_W-1:0] lock_q;
  logic              err_q;
  logic              my_turn;

  assign my_turn = (ticket_q == serving_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ticket_q <= '0;
      lock_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= rel_i && (state_q != ST_HOLD);
      unique case (state_q)
        ST_IDLE: if (take_i) begin
          ticket_q <= ticket_i;
          lock_q   <= sel_i;
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (my_turn) state_q <= ST_HOLD;
        ST_HOLD: if (rel_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign grant_o  = (state_q == ST_HOLD);
  assign err_o    = err_q;
  assign lock_o   = lock_q;
  assign ticket_o = ticket_q;

endmodule

// File: rtl/tkl_unit.sv
module tkl_unit
  import tkl_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        acq_i,
  input  logic [NUM_REQ*LOCK_W-1:0] acq_lock_i,
  input  logic [NUM_REQ-1:0]        rel_i,
  output logic [NUM_REQ-1:0]        grant_o,
  output logic [NUM_REQ-1:0]        err_o
);

  localparam int CNT_W = $clog2(NUM_REQ + 1);

  // named internal events, also observed by the checker
  logic [NUM_REQ-1:0]                  idle, take, adv_req;
  logic [NUM_REQ-1:0][LOCK_W-1:0]      sel, lock_of;
  logic [NUM_REQ-1:0][CNT_W-1:0]       base_tk, tk_of, serv_of;
  logic [NUM_LOCKS-1:0][NUM_REQ-1:0]   take_mask;
  logic [NUM_LOCKS-1:0][CNT_W-1:0]     take_cnt, next_tk, serv_tk;
  logic [NUM_LOCKS-1:0]                lock_adv;

  // acquire split by lock, tickets ranked in ascending requester order
  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      sel[i]  = acq_lock_i[i*LOCK_W +: LOCK_W];
      take[i] = acq_i[i] && idle[i] &&
                ({1'b0, sel[i]} < (LOCK_W+1)'(NUM_LOCKS));
      adv_req[i] = rel_i[i] && grant_o[i];
    end
    for (int l = 0; l < NUM_LOCKS; l++) begin
      lock_adv[l] = 1'b0;
      for (int i = 0; i < NUM_REQ; i++) begin
        take_mask[l][i] = take[i] && (sel[i] == LOCK_W'(l));
        if (adv_req[i] && (lock_of[i] == LOCK_W'(l))) lock_adv[l] = 1'b1;
      end
      take_cnt[l] = CNT_W'(count_all(32'(take_mask[l])));
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      base_tk[i] = '0;
      serv_of[i] = '0;
      for (int l = 0; l < NUM_LOCKS; l++) begin
        if (sel[i] == LOCK_W'(l))
          base_tk[i] = next_tk[l] + CNT_W'(count_below(32'(take_mask[l]), i));
        if (lock_of[i] == LOCK_W'(l))
          serv_of[i] = serv_tk[l];
      end
    end
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_slot
    tkl_slot #(.CNT_W(CNT_W)) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_cnt_i (take_cnt[l]),
      .advance_i  (lock_adv[l]),
      .next_o     (next_tk[l]),
      .serving_o  (serv_tk[l])
    );
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_client
    tkl_client #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) i_client (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (take[i]),
      .sel_i     (sel[i]),
      .ticket_i  (base_tk[i]),
      .serving_i (serv_of[i]),
      .rel_i     (rel_i[i]),
      .idle_o    (idle[i]),
      .grant_o   (grant_o[i]),
      .err_o     (err_o[i]),
      .lock_o    (lock_of[i]),
      .ticket_o  (tk_of[i])
    );
  end

endmodule

// File: rtl/tkl_unit_chk.sv
module tkl_unit_chk #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_W    = 1,
  parameter int CNT_W     = 3
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_REQ-1:0]                rel_i,
  input logic [NUM_REQ-1:0]                grant_o,
  input logic [NUM_REQ-1:0]                err_o,
  input logic [NUM_REQ-1:0][LOCK_W-1:0]    lock_of,
  input logic [NUM_REQ-1:0][CNT_W-1:0]     tk_of,
  input logic [NUM_LOCKS-1:0][CNT_W-1:0]   serv_tk,
  input logic [NUM_LOCKS-1:0][CNT_W-1:0]   next_tk,
  input logic [NUM_LOCKS-1:0][CNT_W-1:0]   take_cnt,
  input logic [NUM_LOCKS-1:0]              lock_adv
);

  logic [NUM_LOCKS-1:0][NUM_REQ-1:0] hold_mask;

  always_comb begin
    for (int l = 0; l < NUM_LOCKS; l++)
      for (int i = 0; i < NUM_REQ; i++)
        hold_mask[l][i] = grant_o[i] && (lock_of[i] == LOCK_W'(l));
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    assert_one_holder_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hold_mask[l]));
    assert_serve_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_adv[l] |=> serv_tk[l] == CNT_W'($past(serv_tk[l]) + 1'b1));
    assert_serve_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_adv[l] |=> $stable(serv_tk[l]));
    assert_ticket_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> next_tk[l] == CNT_W'($past(next_tk[l]) + $past(take_cnt[l])));
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assert_bad_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i[i] && !grant_o[i]) |=> err_o[i]);
    assert_release_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i[i] && grant_o[i]) |=> (!grant_o[i] && !err_o[i]));
    assert_grant_turn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(grant_o[i]) |-> $past(tk_of[i] == serv_tk[lock_of[i]]));
  end

endmodule

bind tkl_unit tkl_unit_chk #(
  .NUM_REQ(NUM_REQ), .NUM_LOCKS(NUM_LOCKS), .LOCK_W(LOCK_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rel_i    (rel_i),
  .grant_o  (grant_o),
  .err_o    (err_o),
  .lock_of  (lock_of),
  .tk_of    (tk_of),
  .serv_tk  (serv_tk),
  .next_tk  (next_tk),
  .take_cnt (take_cnt),
  .lock_adv (lock_adv)
);

// File: tb/test_tkl_unit.sv
module test_tkl_unit;

  localparam int NR = 4;
  localparam int NL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] acq = '0, rel = '0, sel = '0;
  logic [NR-1:0] grant, err;

  int n_chk = 0, n_fail = 0, n_cyc = 0;

  // behavioural reference: one FIFO of requester ids per lock
  int wq[NL][$];
  bit hold_m[NR];
  int lk_m[NR];
  logic [NR-1:0] grant_m = '0, err_m = '0;

  always #2 clk = ~clk;  // 250 MHz

  tkl_unit #(.NUM_REQ(NR), .NUM_LOCKS(NL)) i_tkl_unit (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .acq_lock_i(sel),
    .rel_i(rel), .grant_o(grant), .err_o(err)
  );

  task automatic check(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, n_cyc);
    end
  endtask

  function automatic bit queued(input int r);
    for (int l = 0; l < NL; l++)
      foreach (wq[l][k]) if (wq[l][k] == r) return 1;
    return 0;
  endfunction

  task automatic model_step(input logic [NR-1:0] a, input logic [NR-1:0] s, input logic [NR-1:0] r);
    bit busy[NR];
    bit gm[NR];
    for (int i = 0; i < NR; i++) begin busy[i] = queued(i); gm[i] = 0; end
    for (int l = 0; l < NL; l++)
      if (wq[l].size() > 0 && !hold_m[wq[l][0]]) gm[wq[l][0]] = 1;
    err_m = '0;
    for (int i = 0; i < NR; i++) begin
      if (r[i]) begin
        if (hold_m[i]) begin
          void'(wq[lk_m[i]].pop_front());
          hold_m[i] = 0;
        end else err_m[i] = 1'b1;
      end
    end
    for (int i = 0; i < NR; i++) begin
      if (a[i] && !busy[i]) begin
        lk_m[i] = int'(s[i]);
        wq[lk_m[i]].push_back(i);
      end
    end
    for (int i = 0; i < NR; i++) begin
      if (gm[i]) hold_m[i] = 1;
      grant_m[i] = hold_m[i];
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input logic [NR-1:0] a, input logic [NR-1:0] s,
                     input logic [NR-1:0] r, input string tag);
    acq = a; sel = s; rel = r;
    @(posedge clk);
    model_step(a, s, r);
    @(negedge clk);
    acq = '0; rel = '0;
    check({tag, " grant"}, grant, grant_m);
    check({tag, " err"}, err, err_m);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc('0, '0, '0, tag);
  endtask

  always @(posedge clk) n_cyc++;

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin hold_m[i] = 0; lk_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset grant", grant, '0);
    check("R1 reset err", err, '0);
    idle(1, "R1");

    // R2: free lock, grant after second edge
    cyc(4'b0001, 4'b0000, '0, "R2");
    check("R2 not yet", grant, 4'b0000);
    idle(1, "R2");
    check("R2 granted", grant, 4'b0001);

    // R4 / R11: arrivals in different cycles, single-cycle pulses
    cyc(4'b0100, 4'b0000, '0, "R11");
    cyc(4'b0010, 4'b0000, '0, "R4");
    idle(2, "R4");
    check("R3 one owner", grant, 4'b0001);
    cyc('0, '0, 4'b0001, "R6");
    check("R6 drop", grant, 4'b0000);
    idle(1, "R6");
    check("R4 second is r2", grant, 4'b0100);
    cyc('0, '0, 4'b0100, "R4");
    idle(1, "R4");
    check("R4 third is r1", grant, 4'b0010);

    // R7: release from non-owner r3
    cyc('0, '0, 4'b1000, "R7");
    check("R7 err pulse", err, 4'b1000);
    check("R7 grants unchanged", grant, 4'b0010);
    idle(1, "R7");
    check("R7 err clears", err, 4'b0000);
    cyc('0, '0, 4'b0010, "R6");
    idle(1, "R6");

    // R5: simultaneous arrivals on lock 1
    cyc(4'b1111, 4'b1111, '0, "R5");
    idle(1, "R5");
    check("R5 lowest index first", grant, 4'b0001);
    // R8: owner and waiter re-acquire, ignored
    cyc(4'b0011, 4'b1111, '0, "R8");
    idle(1, "R8");
    for (int i = 0; i < NR; i++) begin
      cyc('0, '0, 4'(1 << i), "R5");
      idle(1, "R5");
    end
    check("R8 lock free", grant, 4'b0000);
    cyc(4'b0100, 4'b0100, '0, "R8");
    idle(1, "R8");
    check("R8 not blocked", grant, 4'b0100);
    cyc('0, '0, 4'b0100, "R8");

    // R9: independent locks
    cyc(4'b1001, 4'b1000, '0, "R9");
    idle(1, "R9");
    check("R9 both granted", grant, 4'b1001);
    cyc('0, '0, 4'b1001, "R9");
    idle(1, "R9");

    // R10: wrap of the counters over many rounds
    for (int k = 0; k < 20; k++) begin
      cyc(4'(1 << (k % NR)) | 4'(1 << ((k + 1) % NR)), 4'b1111, '0, "R10");
      idle(1, "R10");
      cyc('0, '0, grant, "R10");
      idle(1, "R10");
      cyc('0, '0, grant, "R10");
      idle(1, "R10");
    end
    check("R10 all free", grant, 4'b0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule